// File: doc/BRIEF.md
# ALU Operation Select Decoder

This block sits between the main instruction decoder and the arithmetic unit of a single-cycle processor. It takes a 2-bit class code from the main decoder and the 6-bit function field of the current instruction. From these it forms a 3-bit code that tells the arithmetic unit which operation to carry out.

Memory accesses need an address sum, so they always select addition. Conditional branches compare two registers by subtracting them, so they always select subtraction. Register-to-register instructions take their operation from the function field. A function value outside the supported set falls back to addition, so the arithmetic unit never sees an undefined select.

The block is purely combinational. The output follows the inputs with no clock and no stored state.

Top module: `exop_decoder`

## Requirements
- R1: With class code 2'b00 (memory access), the select is 3'b010 (add) for every one of the 64 function values.
- R2: With class code 2'b01 (branch compare), the select is 3'b110 (subtract) for every one of the 64 function values.
- R3: With class code 2'b10 (register op), function 6'b100000 gives select 3'b010 (add) and function 6'b100010 gives select 3'b110 (subtract).
- R4: With class code 2'b10, function 6'b100100 gives select 3'b000 (bitwise and) and function 6'b100101 gives select 3'b001 (bitwise or).
- R5: With class code 2'b10, function 6'b101010 gives select 3'b111 (set-on-less-than).
- R6: With class code 2'b10, each of the 59 function values other than the five above gives select 3'b010 (add).
- R7: Class code 2'b11 (unassigned) gives select 3'b010 (add) for every function value.
- R8: The select depends only on the present inputs. After any input change it settles within the same time step, with no clock edge and no memory of earlier inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mode_i | input | 2 | Instruction class code from the main decoder |
| fn_i | input | 6 | Function field of the current instruction |
| sel_o | output | 3 | Operation select sent to the arithmetic unit |

## Verification
The bench builds the block with its default widths: a 2-bit class code, a 6-bit function field and a 3-bit select. At these sizes the whole input space has only 256 points, so every class code is swept against every function value. This covers the ignored-field cases under memory, branch and unassigned classes, and the default path for all 59 unsupported function values. A separate scenario changes the inputs several times between clock edges. Each result is sampled before the next edge, which shows that the output carries no state from one input to the next.

// File: rtl/exop_pkg.sv
package exop_pkg;

  localparam int MODE_W = 2;
  localparam int FN_W   = 6;
  localparam int SEL_W  = 3;
  localparam int N_FN   = 5;

  typedef enum logic [1:0] {
    MODE_MEM = 2'b00,
    MODE_BR  = 2'b01,
    MODE_REG = 2'b10,
    MODE_RSV = 2'b11
  } mode_e;

  localparam logic [SEL_W-1:0] SEL_AND = 3'b000;
  localparam logic [SEL_W-1:0] SEL_OR  = 3'b001;
  localparam logic [SEL_W-1:0] SEL_ADD = 3'b010;
  localparam logic [SEL_W-1:0] SEL_SUB = 3'b110;
  localparam logic [SEL_W-1:0] SEL_SLT = 3'b111;

  // function-field codes and the select each one maps to, same index
  localparam logic [FN_W-1:0] FN_CODE [N_FN] = '{
    6'b100000, 6'b100010, 6'b100100, 6'b100101, 6'b101010
  };
  localparam logic [SEL_W-1:0] FN_SEL [N_FN] = '{
    SEL_ADD, SEL_SUB, SEL_AND, SEL_OR, SEL_SLT
  };

  // select for a class code, given the function-field result
  function automatic logic [SEL_W-1:0] class_sel(
    input logic [MODE_W-1:0] mode,
    input logic [SEL_W-1:0]  fn_sel
  );
    logic [SEL_W-1:0] r;
    unique case (mode)
      MODE_BR:  r = SEL_SUB;
      MODE_REG: r = fn_sel;
      default:  r = SEL_ADD;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/exop_fn_match.sv
module exop_fn_match
  import exop_pkg::*;
#(
  parameter int FW = FN_W,
  parameter int SW = SEL_W,
  parameter int NC = N_FN
) (
  input  logic [FW-1:0] fn_i,
  output logic [NC-1:0] hit_o,
  output logic          known_o,
  output logic [SW-1:0] sel_o
);

  genvar gi;
  generate
    for (gi = 0; gi < NC; gi++) begin : g_cmp
      assign hit_o[gi] = (fn_i == FW'(FN_CODE[gi]));
    end
  endgenerate

  assign known_o = |hit_o;

  always_comb begin
    sel_o = SW'(SEL_ADD);
    for (int i = 0; i < NC; i++) begin
      if (hit_o[i]) sel_o = SW'(FN_SEL[i]);
    end
  end

endmodule

// File: rtl/exop_class_mux.sv
module exop_class_mux
  import exop_pkg::*;
#(
  parameter int MW = MODE_W,
  parameter int SW = SEL_W
) (
  input  logic [MW-1:0] mode_i,
  input  logic [SW-1:0] fn_sel_i,
  output logic [SW-1:0] sel_o,
  output logic          use_fn_o
);

  assign use_fn_o = (mode_i == MW'(MODE_REG));
  assign sel_o    = class_sel(mode_i, fn_sel_i);

endmodule

// File: rtl/exop_decoder.sv
module exop_decoder
  import exop_pkg::*;
#(
  parameter int MW = MODE_W,
  parameter int FW = FN_W,
  parameter int SW = SEL_W
) (
  input  logic [MW-1:0] mode_i,
  input  logic [FW-1:0] fn_i,
  output logic [SW-1:0] sel_o
);

  localparam int NC = N_FN;

  logic [NC-1:0] fn_hit;
  logic          fn_known;
  logic [SW-1:0] fn_sel;
  logic          use_fn;

  exop_fn_match #(.FW(FW), .SW(SW), .NC(NC)) u_match (
    .fn_i    (fn_i),
    .hit_o   (fn_hit),
    .known_o (fn_known),
    .sel_o   (fn_sel)
  );

  exop_class_mux #(.MW(MW), .SW(SW)) u_mux (
    .mode_i   (mode_i),
    .fn_sel_i (fn_sel),
    .sel_o    (sel_o),
    .use_fn_o (use_fn)
  );

  always_comb begin
    if (!$isunknown({mode_i, fn_i})) begin
      if (mode_i == MW'(MODE_MEM))
        p_mem_add_r1: assert (sel_o == SW'(SEL_ADD)) else $error("R1 select");
      if (mode_i == MW'(MODE_BR))
        p_branch_sub_r2: assert (sel_o == SW'(SEL_SUB)) else $error("R2 select");
      if (use_fn && fn_hit[NC-1])
        p_slt_sel_r5: assert (sel_o == SW'(SEL_SLT)) else $error("R5 select");
      if (use_fn && !fn_known)
        p_unknown_fn_add_r6: assert (sel_o == SW'(SEL_ADD)) else $error("R6 select");
      if (mode_i == MW'(MODE_RSV))
        p_reserved_add_r7: assert (sel_o == SW'(SEL_ADD)) else $error("R7 select");
      p_single_match_r8: assert ($onehot0(fn_hit)) else $error("R8 match");
    end
  end

endmodule

// File: tb/sim_exop_decoder.sv
module sim_exop_decoder;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic       clk = 1'b0;
  logic [1:0] mode;
  logic [5:0] fn;
  logic [2:0] sel;
  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  exop_decoder u0 (.mode_i(mode), .fn_i(fn), .sel_o(sel));

  function automatic logic [2:0] expect_sel(input logic [1:0] m, input logic [5:0] f);
    if (m == 2'b01) return 3'b110;
    if (m != 2'b10) return 3'b010;
    if (f == 6'h20) return 3'b010;
    if (f == 6'h22) return 3'b110;
    if (f == 6'h24) return 3'b000;
    if (f == 6'h25) return 3'b001;
    if (f == 6'h2a) return 3'b111;
    return 3'b010;
  endfunction

  task automatic apply_check(input string tag, input logic [1:0] m, input logic [5:0] f);
    logic [2:0] e;
    mode = m; fn = f;
    #1;
    e = expect_sel(m, f);
    n_run++;
    if (sel !== e) begin
      n_fail++;
      $display("FAIL %s mode=%b fn=%b got=%b exp=%b", tag, m, f, sel, e);
    end
  endtask

  task automatic t_init;  // R1 reset state: all-zero inputs
    @(negedge clk);
    apply_check("R1", 2'b00, 6'b000000);
  endtask

  task automatic t_mem;
    for (int f = 0; f < 64; f++) begin
      @(negedge clk); apply_check("R1", 2'b00, 6'(f));
    end
  endtask

  task automatic t_branch;
    for (int f = 0; f < 64; f++) begin
      @(negedge clk); apply_check("R2", 2'b01, 6'(f));
    end
  endtask

  task automatic t_arith;
    @(negedge clk); apply_check("R3", 2'b10, 6'b100000);
    @(negedge clk); apply_check("R3", 2'b10, 6'b100010);
  endtask

  task automatic t_logic;
    @(negedge clk); apply_check("R4", 2'b10, 6'b100100);
    @(negedge clk); apply_check("R4", 2'b10, 6'b100101);
  endtask

  task automatic t_slt;
    @(negedge clk); apply_check("R5", 2'b10, 6'b101010);
  endtask

  task automatic t_other;
    for (int f = 0; f < 64; f++) begin
      if (f != 32 && f != 34 && f != 36 && f != 37 && f != 42) begin
        @(negedge clk); apply_check("R6", 2'b10, 6'(f));
      end
    end
  endtask

  task automatic t_reserved;
    for (int f = 0; f < 64; f++) begin
      @(negedge clk); apply_check("R7", 2'b11, 6'(f));
    end
  endtask

  task automatic t_no_state;  // R8: several changes inside one clock period
    @(posedge clk); #1;
    apply_check("R8", 2'b10, 6'b101010);
    apply_check("R8", 2'b10, 6'b100100);
    apply_check("R8", 2'b01, 6'b100100);
    apply_check("R8", 2'b10, 6'b000111);
    apply_check("R8", 2'b10, 6'b100101);
  endtask

  initial begin
    mode = 2'b00; fn = 6'b000000;
    t_init();
    t_mem();
    t_branch();
    t_arith();
    t_logic();
    t_slt();
    t_other();
    t_reserved();
    t_no_state();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < WATCHDOG && !done; c++) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired got=running exp=done");
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule